// File: doc/BRIEF.md
# Modem Handshake Status Monitor

This block sits beside a serial port. It drives the two handshake lines that go out to a modem: request-to-send and data-terminal-ready. It also watches the four lines that come back: clear-to-send, data-set-ready, carrier-detect and ring-indicator. Each returning line passes through a synchroniser. The synchronised level is presented on a status vector, and a sticky change flag is kept for each line. The flags of the clear-to-send, data-set-ready and carrier-detect lines record a transition in either direction. The ring-indicator flag records only the end of a ring, that is, the line falling from high to low. An interrupt request goes out whenever any flag is set and interrupts are enabled. Reading the status clears the flags.

For self-test, a loop setting disconnects the block from the outside world. The two handshake outputs and two spare control bits are fed back into the status inputs. The external handshake outputs are parked low, the serial line output is parked at its idle high level, and the serial transmit stream is returned to the serial receive path. The control bits and the read strobe come from a register interface that lives outside this block.

Top module: `hs_modem_monitor`

## Requirements
- R1: While rst_n is low, stat_level, stat_delta and irq are all 0, whatever the inputs are.
- R2: stat_level shows each status source as it was sampled two rising clock edges earlier. The bit order is bit 0 clear-to-send, bit 1 data-set-ready, bit 2 ring-indicator, bit 3 carrier-detect.
- R3: A change in either direction of stat_level bit 0, 1 or 3 sets the matching stat_delta bit on the same edge.
- R4: stat_delta bit 2 is set only when stat_level bit 2 goes from 1 to 0. A rise of that bit leaves the flag unchanged.
- R5: A set stat_delta bit stays set until status_rd is sampled high on a rising edge. That edge clears every flag that has no new event on it.
- R6: When status_rd is sampled on the same edge as a new event, the flag of that event is set after the edge. The new event wins over the clear.
- R7: irq is 1 exactly when cfg_irq_en is 1 and at least one stat_delta bit is 1.
- R8: With cfg_loop at 0, pin_rts follows cfg_rts and pin_dtr follows cfg_dtr. ser_tx_pin follows ser_tx_in and ser_rx_out follows ser_rx_pin.
- R9: With cfg_loop at 1, pin_rts and pin_dtr are 0, ser_tx_pin is 1, and ser_rx_out follows ser_tx_in.
- R10: With cfg_loop at 1, the status sources are taken from inside the block: cfg_rts feeds bit 0, cfg_dtr feeds bit 1, cfg_aux_ri feeds bit 2 and cfg_aux_dcd feeds bit 3. The four external status pins have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_loop | input | 1 | Self-test loop enable |
| cfg_irq_en | input | 1 | Interrupt enable |
| cfg_rts | input | 1 | Request-to-send control bit |
| cfg_dtr | input | 1 | Data-terminal-ready control bit |
| cfg_aux_ri | input | 1 | Spare control bit, looped to ring-indicator |
| cfg_aux_dcd | input | 1 | Spare control bit, looped to carrier-detect |
| status_rd | input | 1 | Status read strobe, clears the flags |
| pin_cts | input | 1 | External clear-to-send |
| pin_dsr | input | 1 | External data-set-ready |
| pin_dcd | input | 1 | External carrier-detect |
| pin_ri | input | 1 | External ring-indicator |
| pin_rts | output | 1 | External request-to-send |
| pin_dtr | output | 1 | External data-terminal-ready |
| ser_tx_in | input | 1 | Serial stream from the transmitter |
| ser_tx_pin | output | 1 | Serial line output |
| ser_rx_pin | input | 1 | Serial line input |
| ser_rx_out | output | 1 | Serial stream to the receiver |
| stat_level | output | 4 | Synchronised status levels |
| stat_delta | output | 4 | Sticky change flags |
| irq | output | 1 | Interrupt request |

## Verification
Two functions can fall on the same rising edge: a read strobe that clears the flags, and a synchronised status change that sets one. The bench provokes this by raising status_rd exactly one cycle after a carrier-detect pin change, so that the strobe is sampled on the edge where the synchronised level moves. An older pending data-set-ready flag is present at the same time. The result is judged by requiring the carrier-detect flag to survive while the older flag is cleared. A behavioural model, compared on every clock during a long pseudo-random phase, also meets many accidental collisions of the two functions, including some in loop mode.

// File: rtl/hs_modem_pkg.sv
package hs_modem_pkg;
    localparam int unsigned STAT_W  = 4;
    localparam int unsigned IDX_CTS = 0;
    localparam int unsigned IDX_DSR = 1;
    localparam int unsigned IDX_RI  = 2;
    localparam int unsigned IDX_DCD = 3;

    typedef logic [STAT_W-1:0] stat_vec_t;

    // lines whose flag records only the high-to-low transition
    localparam stat_vec_t TRAIL_ONLY = stat_vec_t'(1 << IDX_RI);
endpackage

// File: rtl/hs_loop_steer.sv
module hs_loop_steer
    import hs_modem_pkg::*;
#(
    parameter logic LINE_IDLE  = 1'b1,
    parameter logic HS_PARKED  = 1'b0
) (
    input  logic      loop_en,
    input  logic      ctl_rts,
    input  logic      ctl_dtr,
    input  logic      ctl_aux_ri,
    input  logic      ctl_aux_dcd,
    input  stat_vec_t ext_stat,
    input  logic      tx_from_uart,
    input  logic      rx_from_line,
    output stat_vec_t stat_src,
    output logic      line_rts,
    output logic      line_dtr,
    output logic      tx_to_line,
    output logic      rx_to_uart
);
    stat_vec_t fed_back;

    always_comb begin
        fed_back          = '0;
        fed_back[IDX_CTS] = ctl_rts;
        fed_back[IDX_DSR] = ctl_dtr;
        fed_back[IDX_RI]  = ctl_aux_ri;
        fed_back[IDX_DCD] = ctl_aux_dcd;
    end

    always_comb begin
        if (loop_en) begin
            stat_src   = fed_back;
            line_rts   = HS_PARKED;
            line_dtr   = HS_PARKED;
            tx_to_line = LINE_IDLE;
            rx_to_uart = tx_from_uart;
        end else begin
            stat_src   = ext_stat;
            line_rts   = ctl_rts;
            line_dtr   = ctl_dtr;
            tx_to_line = tx_from_uart;
            rx_to_uart = rx_from_line;
        end
    end
endmodule

// File: rtl/hs_sync_chain.sv
module hs_sync_chain #(
    parameter int unsigned WIDTH  = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] incoming
);
    localparam int unsigned LAST = STAGES - 1;

    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] stg;
    } chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d        = chain_q;
        chain_d.stg[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d.stg[i] = chain_q.stg[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    // level is the settled value; incoming becomes the level on the next edge
    assign level    = chain_q.stg[LAST];
    assign incoming = chain_q.stg[LAST-1];
endmodule

// File: rtl/hs_delta_track.sv
module hs_delta_track #(
    parameter int unsigned      WIDTH      = 4,
    parameter logic [WIDTH-1:0] TRAIL_MASK = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level,
    input  logic [WIDTH-1:0] incoming,
    input  logic             clr,
    output logic [WIDTH-1:0] flag
);
    typedef struct packed {
        logic [WIDTH-1:0] flag;
    } trk_t;

    trk_t             trk_d, trk_q;
    logic [WIDTH-1:0] evt;

    for (genvar b = 0; b < WIDTH; b++) begin : g_evt
        if (TRAIL_MASK[b]) begin : g_trail
            assign evt[b] = level[b] & ~incoming[b];
        end else begin : g_any
            assign evt[b] = level[b] ^ incoming[b];
        end
    end

    always_comb begin
        trk_d = trk_q;
        if (clr) trk_d.flag = '0;
        trk_d.flag = trk_d.flag | evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign flag = trk_q.flag;
endmodule

// File: rtl/hs_modem_monitor.sv
module hs_modem_monitor
    import hs_modem_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_loop,
    input  logic              cfg_irq_en,
    input  logic              cfg_rts,
    input  logic              cfg_dtr,
    input  logic              cfg_aux_ri,
    input  logic              cfg_aux_dcd,
    input  logic              status_rd,
    input  logic              pin_cts,
    input  logic              pin_dsr,
    input  logic              pin_dcd,
    input  logic              pin_ri,
    output logic              pin_rts,
    output logic              pin_dtr,
    input  logic              ser_tx_in,
    output logic              ser_tx_pin,
    input  logic              ser_rx_pin,
    output logic              ser_rx_out,
    output logic [STAT_W-1:0] stat_level,
    output logic [STAT_W-1:0] stat_delta,
    output logic              irq
);
    stat_vec_t ext_stat, src, lvl, nxt, flg;

    always_comb begin
        ext_stat          = '0;
        ext_stat[IDX_CTS] = pin_cts;
        ext_stat[IDX_DSR] = pin_dsr;
        ext_stat[IDX_RI]  = pin_ri;
        ext_stat[IDX_DCD] = pin_dcd;
    end

    hs_loop_steer #(
        .LINE_IDLE (1'b1),
        .HS_PARKED (1'b0)
    ) u_steer (
        .loop_en      (cfg_loop),
        .ctl_rts      (cfg_rts),
        .ctl_dtr      (cfg_dtr),
        .ctl_aux_ri   (cfg_aux_ri),
        .ctl_aux_dcd  (cfg_aux_dcd),
        .ext_stat     (ext_stat),
        .tx_from_uart (ser_tx_in),
        .rx_from_line (ser_rx_pin),
        .stat_src     (src),
        .line_rts     (pin_rts),
        .line_dtr     (pin_dtr),
        .tx_to_line   (ser_tx_pin),
        .rx_to_uart   (ser_rx_out)
    );

    hs_sync_chain #(
        .WIDTH  (STAT_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (src),
        .level    (lvl),
        .incoming (nxt)
    );

    hs_delta_track #(
        .WIDTH      (STAT_W),
        .TRAIL_MASK (TRAIL_ONLY)
    ) u_delta (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (lvl),
        .incoming (nxt),
        .clr      (status_rd),
        .flag     (flg)
    );

    assign stat_level = lvl;
    assign stat_delta = flg;
    assign irq        = cfg_irq_en & (|flg);
endmodule

// File: rtl/hs_modem_monitor_chk.sv
module hs_modem_monitor_chk
    import hs_modem_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_loop,
    input logic              cfg_irq_en,
    input logic              status_rd,
    input logic              pin_rts,
    input logic              pin_dtr,
    input logic              ser_tx_in,
    input logic              ser_tx_pin,
    input logic              ser_rx_out,
    input logic [STAT_W-1:0] stat_level,
    input logic [STAT_W-1:0] stat_delta,
    input logic              irq
);
    localparam stat_vec_t BOTH_WAYS = ~TRAIL_ONLY;

    // R5: without a read strobe no flag is lost
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> ((stat_delta & $past(stat_delta)) == $past(stat_delta)));

    // R5: after a read only flags backed by a level move on that edge remain
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> ((stat_delta & ~(stat_level ^ $past(stat_level))) == '0));

    // R3: a level move on a both-ways line always leaves its flag set
    p_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_level ^ $past(stat_level)) & BOTH_WAYS & ~stat_delta) == '0);

    // R6: a read on the edge of a move does not drop that move's flag
    p_setwins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        status_rd |=> (((stat_level ^ $past(stat_level)) & BOTH_WAYS & ~stat_delta) == '0));

    // R4: a ring-indicator rise never raises its flag
    p_ri_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_level[IDX_RI] && !$past(stat_level[IDX_RI]) && !$past(stat_delta[IDX_RI]))
            |-> !stat_delta[IDX_RI]);

    // R4: a ring-indicator fall always raises its flag
    p_ri_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_level[IDX_RI] && $past(stat_level[IDX_RI])) |-> stat_delta[IDX_RI]);

    // R7: request present with an enabled pending flag, absent when disabled
    p_irq_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_irq_en && (stat_delta != '0)) |-> irq);
    p_irq_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_irq_en || (stat_delta == '0)) |-> !irq);

    // R9: loop parks the outside lines and returns the transmit stream
    p_loop_park_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_loop |-> (!pin_rts && !pin_dtr && ser_tx_pin && (ser_rx_out == ser_tx_in)));
endmodule

bind hs_modem_monitor hs_modem_monitor_chk u_chk (.*);

// File: tb/hs_modem_monitor_test.sv
`timescale 1ns/1ps
module hs_modem_monitor_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_loop = 0, cfg_irq_en = 0, cfg_rts = 0, cfg_dtr = 0;
    logic cfg_aux_ri = 0, cfg_aux_dcd = 0, status_rd = 0;
    logic pin_cts = 0, pin_dsr = 0, pin_dcd = 0, pin_ri = 0;
    logic ser_tx_in = 0, ser_rx_pin = 0;
    logic pin_rts, pin_dtr, ser_tx_pin, ser_rx_out, irq;
    logic [3:0] stat_level, stat_delta;

    int  total = 0;
    int  bad   = 0;
    bit  done  = 0;

    always #2.5 clk = ~clk;

    hs_modem_monitor uut (
        .clk(clk), .rst_n(rst_n), .cfg_loop(cfg_loop), .cfg_irq_en(cfg_irq_en),
        .cfg_rts(cfg_rts), .cfg_dtr(cfg_dtr), .cfg_aux_ri(cfg_aux_ri),
        .cfg_aux_dcd(cfg_aux_dcd), .status_rd(status_rd),
        .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_dcd(pin_dcd), .pin_ri(pin_ri),
        .pin_rts(pin_rts), .pin_dtr(pin_dtr), .ser_tx_in(ser_tx_in),
        .ser_tx_pin(ser_tx_pin), .ser_rx_pin(ser_rx_pin), .ser_rx_out(ser_rx_out),
        .stat_level(stat_level), .stat_delta(stat_delta), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model: history of sampled sources, newest first
    logic [3:0] hist[$] = '{4'h0, 4'h0, 4'h0};
    logic [3:0] m_delta = 4'h0;
    logic [3:0] m_ev;

    function automatic logic [3:0] src_now();
        // bit order: 0 CTS, 1 DSR, 2 RI, 3 DCD
        if (cfg_loop) return {cfg_aux_dcd, cfg_aux_ri, cfg_dtr, cfg_rts};
        return {pin_dcd, pin_ri, pin_dsr, pin_cts};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist    = '{4'h0, 4'h0, 4'h0};
            m_delta = 4'h0;
        end else begin
            hist.push_front(src_now());
            void'(hist.pop_back());
            m_ev = 4'h0;
            for (int b = 0; b < 4; b++) begin
                if (b == 2) m_ev[b] = hist[2][b] && !hist[1][b];
                else        m_ev[b] = hist[2][b] != hist[1][b];
            end
            if (status_rd) m_delta = 4'h0;
            m_delta = m_delta | m_ev;
        end
    end

    // continuous comparison shortly after each rising edge
    always begin
        @(posedge clk);
        #1;
        if (rst_n && !done) begin
            check(cfg_loop ? "R10 level" : "R2 level", 32'(stat_level), 32'(hist[1]));
            for (int b = 0; b < 4; b++)
                check(b == 2 ? "R4 ri flag" : "R3 flag", 32'(stat_delta[b]), 32'(m_delta[b]));
            check("R7 irq", 32'(irq), 32'(cfg_irq_en & (|m_delta)));
            if (cfg_loop)
                check("R9 outputs", 32'({pin_rts, pin_dtr, ser_tx_pin, ser_rx_out}),
                      32'({1'b0, 1'b0, 1'b1, ser_tx_in}));
            else
                check("R8 outputs", 32'({pin_rts, pin_dtr, ser_tx_pin, ser_rx_out}),
                      32'({cfg_rts, cfg_dtr, ser_tx_in, ser_rx_pin}));
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_pulse();
        status_rd = 1'b1;
        tick(1);
        status_rd = 1'b0;
    endtask

    initial begin
        #(200000 * 5.0);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        // R1: reset holds everything low even with active inputs
        cfg_irq_en = 1; pin_cts = 1; pin_ri = 1; pin_dcd = 1;
        tick(3);
        check("R1 level", 32'(stat_level), 0);
        check("R1 flags", 32'(stat_delta), 0);
        check("R1 irq", 32'(irq), 0);
        pin_cts = 0; pin_ri = 0; pin_dcd = 0;
        tick(2);
        rst_n = 1;
        tick(3);

        // R2, R3, R7: CTS rise seen two edges later with flag and request
        pin_cts = 1;
        tick(1);
        check("R2 lag", 32'(stat_level[0]), 0);
        tick(1);
        check("R2 lag", 32'(stat_level[0]), 1);
        check("R3 cts rise", 32'(stat_delta), 32'h1);
        check("R7 irq set", 32'(irq), 1);

        // R5: flag persists, then a read clears it
        tick(4);
        check("R5 hold", 32'(stat_delta), 32'h1);
        rd_pulse();
        check("R5 clear", 32'(stat_delta), 0);
        check("R7 irq clear", 32'(irq), 0);

        // R4: RI rise ignored, fall flagged
        pin_ri = 1;
        tick(3);
        check("R4 rise ignored", 32'(stat_delta[2]), 0);
        pin_ri = 0;
        tick(3);
        check("R4 fall flagged", 32'(stat_delta[2]), 1);
        rd_pulse();

        // R3: DSR fall
        pin_dsr = 1;
        tick(3);
        rd_pulse();
        pin_dsr = 0;
        tick(3);
        check("R3 dsr fall", 32'(stat_delta), 32'h2);

        // R6: DCD move meets the read strobe on the same edge
        pin_dcd = 1;
        tick(1);
        status_rd = 1;
        tick(1);
        status_rd = 0;
        check("R6 set wins", 32'(stat_delta), 32'h8);

        // R7: enable gates the request
        cfg_irq_en = 0;
        #1;
        check("R7 disabled", 32'(irq), 0);
        cfg_irq_en = 1;
        #1;
        check("R7 enabled", 32'(irq), 1);
        tick(1);
        rd_pulse();

        // R8: normal pass-through
        cfg_rts = 1; cfg_dtr = 1; ser_tx_in = 0; ser_rx_pin = 1;
        #1;
        check("R8 pass", 32'({pin_rts, pin_dtr, ser_tx_pin, ser_rx_out}), 32'b1101);
        tick(1);

        // R9, R10: loop mode
        cfg_loop = 1; cfg_rts = 1; cfg_dtr = 0; cfg_aux_ri = 0; cfg_aux_dcd = 1;
        pin_cts = 0; pin_dsr = 1; pin_dcd = 0; pin_ri = 1;
        tick(3);
        check("R10 loop sources", 32'(stat_level), 32'b1001);
        check("R9 parked", 32'({pin_rts, pin_dtr, ser_tx_pin, ser_rx_out}), 32'b0010);
        ser_tx_in = 1;
        #1;
        check("R9 rx loop", 32'(ser_rx_out), 1);
        pin_cts = 1; pin_dsr = 0; pin_dcd = 1; pin_ri = 0;
        tick(3);
        check("R10 pins ignored", 32'(stat_level), 32'b1001);
        cfg_loop = 0;
        tick(3);
        rd_pulse();

        // mixed pseudo-random phase, compared every clock by the model
        lf = 16'hACE1;
        for (int i = 0; i < 800; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (lf[2:0] == 3'd0) pin_cts = ~pin_cts;
            if (lf[5:3] == 3'd1) pin_dsr = ~pin_dsr;
            if (lf[8:6] == 3'd2) pin_ri  = ~pin_ri;
            if (lf[11:9] == 3'd3) pin_dcd = ~pin_dcd;
            status_rd  = (lf[14:12] == 3'd0);
            cfg_rts    = lf[4];
            cfg_dtr    = lf[9];
            cfg_aux_ri = lf[13];
            cfg_aux_dcd = lf[1];
            ser_tx_in  = lf[7];
            ser_rx_pin = lf[10];
            if (lf[15:11] == 5'd7) cfg_loop = ~cfg_loop;
            if (lf[15:10] == 6'd21) cfg_irq_en = ~cfg_irq_en;
            tick(1);
        end
        status_rd = 0;
        tick(4);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule